// File: doc/BRIEF.md
# Command Argument Collector

This block sequences the multi-word commands that software issues through a pair of 32-bit write-only registers. A write to the command register selects an operation. Subsequent writes to the argument register fill a word buffer at an incrementing position. As soon as the argument bytes gathered reach the size that the selected operation requires, the block emits a one-cycle dispatch pulse. The pulse carries the operation number, the number of words gathered and the whole buffer.

An external handler consumes the pulse and drives a result code during that cycle. The block latches this code into its status register and returns to the reserved idle operation. Operations that need no arguments dispatch right after their command write. Identifiers outside the legal range fall back to the reserved operation, which also needs no arguments. Address decode and the handlers themselves live outside this block.

Top module: `cmd_collector`

## Requirements
- R1: After reset the status output reads 0 (success), no dispatch is pending and the overflow flag is low.
- R2: A command write whose value v satisfies 0 < v < 10 selects operation v. Any other value, including 0, 10 and 32'hFFFFFFFF, selects the reserved operation 0.
- R3: A command write clears the argument counter, so partly gathered arguments are discarded. In the cycle after the write the status reads 2 (arguments pending).
- R4: Operations 0, 2, 3, 6 and 8 need no arguments. Each dispatches in the cycle after its command write, with `disp_words` equal to 0.
- R5: The k-th argument write after a command write (k from 0) lands in `disp_args[32k+31:32k]`. Dispatch occurs in the cycle after the write that brings words*4 to at least the size of the operation, with `disp_words` equal to the count gathered.
- R6: The argument sizes in words are: operation 1 needs 6, operation 5 needs 3, operation 9 needs 4, operation 7 needs 2+MSG_PAGES, and operation 4 needs 3+2*RING_PAGES.
- R7: The status output takes the value of `hnd_status` sampled during the dispatch cycle, visible one cycle later. The current operation then returns to 0, so one further argument write dispatches operation 0 with one word.
- R8: A write whose byte enables are not all set (4'hF) has no effect on the counter, the status or dispatch.
- R9: An argument write when the buffer already holds BUF_WORDS words is dropped, causes no dispatch, and sets `ovf_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command register; wins over `arg_we` |
| arg_we | input | 1 | Write strobe for the argument register |
| wr_be | input | 4 | Byte enables of the write; only 4'hF is accepted |
| wr_data | input | 32 | Write data, little-endian word |
| hnd_status | input | 32 | Result code from the handler during a dispatch cycle |
| disp_vld | output | 1 | One-cycle dispatch pulse |
| disp_cmd | output | ID_W | Operation being dispatched |
| disp_words | output | clog2(BUF_WORDS+1) | Argument words gathered for this dispatch |
| disp_args | output | 32*BUF_WORDS | Argument buffer, word k at bits 32k+31:32k |
| cmd_status | output | 32 | Status register: 0 success, 2 pending, else handler code |
| ovf_err | output | 1 | Sticky argument overflow flag |

## Verification
The bench targets the edges of argument gathering: the exact word that triggers dispatch, zero-size and out-of-range identifiers, and a new command written midway through collection. If the counter survived the restart, the restarted operation would dispatch early with misplaced words. If an out-of-range identifier wrapped to a real operation, it would wait for arguments instead of dispatching at once. Partial byte-enable writes between argument words would shift or advance the buffer in a faulty design. Overflow writes would corrupt the buffer, fire spurious dispatches, or leave the flag non-sticky.

// File: rtl/cmd_collector.sv
module cmd_collector #(
  parameter int BUF_WORDS  = 67,
  parameter int RING_PAGES = 32,
  parameter int MSG_PAGES  = 16,
  parameter int ID_W       = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_we,
  input  logic                             arg_we,
  input  logic [3:0]                       wr_be,
  input  logic [31:0]                      wr_data,
  input  logic [31:0]                      hnd_status,
  output logic                             disp_vld,
  output logic [ID_W-1:0]                  disp_cmd,
  output logic [$clog2(BUF_WORDS+1)-1:0]   disp_words,
  output logic [BUF_WORDS*32-1:0]          disp_args,
  output logic [31:0]                      cmd_status,
  output logic                             ovf_err
);

  localparam int CNT_W = $clog2(BUF_WORDS + 1);
  localparam int AW    = $clog2(BUF_WORDS);
  localparam int NCMD  = 10;

  localparam logic [ID_W-1:0] OP_NONE  = ID_W'(0);
  localparam logic [ID_W-1:0] OP_CFG   = ID_W'(1);
  localparam logic [ID_W-1:0] OP_RINGS = ID_W'(4);
  localparam logic [ID_W-1:0] OP_DEVRS = ID_W'(5);
  localparam logic [ID_W-1:0] OP_MSGRG = ID_W'(7);
  localparam logic [ID_W-1:0] OP_ABORT = ID_W'(9);

  localparam logic [31:0] ST_OK   = 32'd0;
  localparam logic [31:0] ST_WAIT = 32'd2;

  function automatic int unsigned need_bytes(input logic [ID_W-1:0] op);
    case (op)
      OP_CFG:   need_bytes = 32'd24;
      OP_RINGS: need_bytes = 32'(4 * (3 + 2 * RING_PAGES));
      OP_DEVRS: need_bytes = 32'd12;
      OP_MSGRG: need_bytes = 32'(4 * (2 + MSG_PAGES));
      OP_ABORT: need_bytes = 32'd16;
      default:  need_bytes = 32'd0;
    endcase
  endfunction

  logic [31:0]     buf_q [BUF_WORDS];
  logic [ID_W-1:0] cur_op;
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic [ID_W-1:0] sel_op;
  logic            full_be, cmd_acc, arg_acc, room, fire;
  int unsigned     got_bytes;

  assign full_be   = (wr_be == 4'hF);
  assign cmd_acc   = cmd_we && full_be;
  assign arg_acc   = arg_we && full_be && !cmd_we;
  assign sel_op    = (wr_data != 32'd0 && wr_data < NCMD) ? wr_data[ID_W-1:0] : OP_NONE;
  assign cnt_inc   = cnt + 1'b1;
  assign room      = (32'(cnt) < BUF_WORDS);
  assign got_bytes = 32'(cnt_inc) * 32'd4;
  assign fire      = got_bytes >= need_bytes(cur_op);

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_flat
    assign disp_args[g*32 +: 32] = buf_q[g];
  end

  always_ff @(posedge clk) begin
    if (arg_acc && room)
      buf_q[cnt[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op     <= OP_NONE;
      cnt        <= '0;
      cmd_status <= ST_OK;
      disp_vld   <= 1'b0;
      disp_cmd   <= OP_NONE;
      disp_words <= '0;
      ovf_err    <= 1'b0;
    end else begin
      disp_vld <= 1'b0;
      if (disp_vld)
        cmd_status <= hnd_status;
      if (cmd_acc) begin
        cnt        <= '0;
        cmd_status <= ST_WAIT;
        if (need_bytes(sel_op) == 32'd0) begin
          disp_vld   <= 1'b1;
          disp_cmd   <= sel_op;
          disp_words <= '0;
          cur_op     <= OP_NONE;
        end else begin
          cur_op <= sel_op;
        end
      end else if (arg_acc) begin
        if (!room) begin
          ovf_err <= 1'b1;
        end else if (fire) begin
          disp_vld   <= 1'b1;
          disp_cmd   <= cur_op;
          disp_words <= cnt_inc;
          cur_op     <= OP_NONE;
          cnt        <= '0;
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_collector_chk.sv
module cmd_collector_chk #(
  parameter int ID_W  = 8,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic             arg_we,
  input logic [3:0]       wr_be,
  input logic [31:0]      hnd_status,
  input logic             disp_vld,
  input logic [ID_W-1:0]  disp_cmd,
  input logic [CNT_W-1:0] disp_words,
  input logic [31:0]      cmd_status,
  input logic             ovf_err
);

  assert_wait_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wr_be == 4'hF) |=> cmd_status == 32'd2);

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_partial_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_we || arg_we) && wr_be != 4'hF && !disp_vld) |=> (!disp_vld && $stable(cmd_status)));

  assert_status_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld && !(cmd_we && wr_be == 4'hF)) |=> cmd_status == $past(hnd_status));

  assert_cfg_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld && disp_cmd == ID_W'(1)) |-> disp_words == CNT_W'(6));

  assert_legal_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> disp_cmd < ID_W'(10));

endmodule

bind cmd_collector cmd_collector_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .arg_we(arg_we), .wr_be(wr_be),
  .hnd_status(hnd_status), .disp_vld(disp_vld), .disp_cmd(disp_cmd),
  .disp_words(disp_words), .cmd_status(cmd_status), .ovf_err(ovf_err)
);

// File: tb/sim_cmd_collector.sv
`timescale 1ns/1ps
module sim_cmd_collector;
  localparam int BW = 8;
  localparam int CW = $clog2(BW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, arg_we = 1'b0;
  logic [3:0] wr_be = 4'h0;
  logic [31:0] wr_data = 32'd0, hnd_status = 32'd0;
  logic disp_vld, ovf_err;
  logic [7:0] disp_cmd;
  logic [CW-1:0] disp_words;
  logic [BW*32-1:0] disp_args;
  logic [31:0] cmd_status;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmd_collector #(.BUF_WORDS(BW), .RING_PAGES(4), .MSG_PAGES(4), .ID_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .arg_we(arg_we), .wr_be(wr_be),
    .wr_data(wr_data), .hnd_status(hnd_status), .disp_vld(disp_vld),
    .disp_cmd(disp_cmd), .disp_words(disp_words), .disp_args(disp_args),
    .cmd_status(cmd_status), .ovf_err(ovf_err));

  localparam int NV = 11;
  localparam logic [31:0] V_ID [NV] = '{32'd1, 32'd2, 32'd3, 32'd5, 32'd6, 32'd8,
                                        32'd9, 32'd0, 32'd10, 32'd12, 32'hFFFFFFFF};
  localparam int V_NW [NV] = '{6, 0, 0, 3, 0, 0, 4, 0, 0, 0, 0};
  localparam int V_EC [NV] = '{1, 2, 3, 5, 6, 8, 9, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit is_cmd, input logic [31:0] d, input logic [3:0] be);
    cmd_we = is_cmd; arg_we = !is_cmd; wr_data = d; wr_be = be;
    @(negedge clk);
    cmd_we = 1'b0; arg_we = 1'b0; wr_be = 4'h0;
  endtask

  task automatic run(input logic [31:0] id, input int nw, input int ec, input logic [31:0] hs, input int tag);
    hnd_status = hs;
    wr(1'b1, id, 4'hF);
    if (nw == 0) begin
      chk(disp_vld == 1'b1, "R4 zero-size dispatch", int'(disp_vld), 1);
      chk(disp_cmd == 8'(ec), "R2 selected op", int'(disp_cmd), ec);
      chk(disp_words == '0, "R4 word count", int'(disp_words), 0);
    end else begin
      chk(disp_vld == 1'b0 && cmd_status == 32'd2, "R3 pending status", int'(cmd_status), 2);
      for (int k = 0; k < nw; k++) begin
        wr(1'b0, 32'hA000_0000 + 32'(tag * 16 + k), 4'hF);
        if (k < nw - 1)
          chk(disp_vld == 1'b0, "R6 no early dispatch", int'(disp_vld), 0);
      end
      chk(disp_vld == 1'b1 && disp_cmd == 8'(ec), "R6 dispatch op", int'(disp_cmd), ec);
      chk(int'(disp_words) == nw, "R5 word count", int'(disp_words), nw);
      for (int k = 0; k < nw; k++)
        chk(disp_args[k*32 +: 32] == 32'hA000_0000 + 32'(tag * 16 + k), "R5 argument word",
            int'(disp_args[k*32 +: 32]), int'(32'hA000_0000 + 32'(tag * 16 + k)));
    end
    @(negedge clk);
    chk(cmd_status == hs, "R7 handler status", int'(cmd_status), int'(hs));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_status == 32'd0, "R1 status", int'(cmd_status), 0);
    chk(disp_vld == 1'b0, "R1 no dispatch", int'(disp_vld), 0);
    chk(ovf_err == 1'b0, "R1 overflow flag", int'(ovf_err), 0);

    for (int i = 0; i < NV; i++)
      run(V_ID[i], V_NW[i], V_EC[i], 32'h100 + 32'(i), i);

    // R6 message ring setup: 2 + MSG_PAGES(4) = 6 words
    run(32'd7, 6, 7, 32'd1, 12);

    // R7 idle argument write dispatches the reserved op with one word
    hnd_status = 32'h55;
    wr(1'b0, 32'hBEEF0001, 4'hF);
    chk(disp_vld && disp_cmd == 8'd0, "R7 idle dispatch op", int'(disp_cmd), 0);
    chk(disp_words == CW'(1) && disp_args[31:0] == 32'hBEEF0001, "R7 idle word",
        int'(disp_args[31:0]), int'(32'hBEEF0001));
    @(negedge clk);
    chk(cmd_status == 32'h55, "R7 idle status", int'(cmd_status), 'h55);

    // R3 restart mid-collection
    wr(1'b1, 32'd1, 4'hF);
    for (int k = 0; k < 3; k++) wr(1'b0, 32'hC0 + 32'(k), 4'hF);
    hnd_status = 32'h77;
    wr(1'b1, 32'd5, 4'hF);
    chk(cmd_status == 32'd2 && !disp_vld, "R3 restart status", int'(cmd_status), 2);
    wr(1'b0, 32'hD0, 4'hF);
    chk(disp_vld == 1'b0, "R3 counter cleared", int'(disp_vld), 0);
    wr(1'b0, 32'hD1, 4'hF);
    wr(1'b0, 32'hD2, 4'hF);
    chk(disp_vld && disp_cmd == 8'd5 && disp_args[31:0] == 32'hD0, "R3 restart args",
        int'(disp_args[31:0]), 'hD0);
    @(negedge clk);

    // R8 partial byte enables
    wr(1'b1, 32'd2, 4'h7);
    chk(disp_vld == 1'b0, "R8 partial command", int'(disp_vld), 0);
    chk(cmd_status == 32'h77, "R8 status kept", int'(cmd_status), 'h77);
    hnd_status = 32'h88;
    wr(1'b1, 32'd1, 4'hF);
    for (int k = 0; k < 6; k++) begin
      wr(1'b0, 32'hE0 + 32'(k), 4'hF);
      if (k == 2) begin
        wr(1'b0, 32'hFFFF, 4'h3);
        chk(disp_vld == 1'b0, "R8 partial argument", int'(disp_vld), 0);
      end
    end
    chk(disp_vld && disp_words == CW'(6) && disp_args[3*32 +: 32] == 32'hE3, "R8 args intact",
        int'(disp_args[3*32 +: 32]), 'hE3);
    @(negedge clk);

    // R9 overflow: op 4 needs 3+2*4 = 11 words, buffer holds 8
    wr(1'b1, 32'd4, 4'hF);
    for (int k = 0; k < BW; k++) wr(1'b0, 32'hF0 + 32'(k), 4'hF);
    chk(disp_vld == 1'b0 && ovf_err == 1'b0, "R9 full no flag", int'(ovf_err), 0);
    wr(1'b0, 32'h1234, 4'hF);
    chk(ovf_err == 1'b1, "R9 flag set", int'(ovf_err), 1);
    chk(disp_vld == 1'b0, "R9 no dispatch", int'(disp_vld), 0);
    chk(disp_args[(BW-1)*32 +: 32] == 32'hF7, "R9 buffer intact",
        int'(disp_args[(BW-1)*32 +: 32]), 'hF7);
    run(32'd6, 0, 6, 32'h99, 13);
    chk(ovf_err == 1'b1, "R9 flag sticky", int'(ovf_err), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule